// File: doc/BRIEF.md
# Processor Bus Fan-Out to Four Board Windows

This block is a bus slave between an external signal processor and four logic boards. The processor drives one shared, strobed memory bus. Each access carries a 32-bit byte address, a read/write flag and 32-bit data. The block decodes the address into one of four board windows and drives the strobe, direction and ready lines of the chosen board. Each window holds a small bank of word registers. A ready signal goes back to the processor after a fixed number of wait cycles.

Board-side logic reports waiting data with a one-cycle event pulse. The pulse sets a data-valid flag for that board, which drives its interrupt line toward the processor. The processor reads the board's status word at offset 0. That read returns the flag and clears it. Addresses in the all-boards-off window, or in the gaps between board windows, select no board. They still complete with ready, so the processor never stalls on a stray address.

Top module: `dsp_board_bus`

## Requirements
- R1: An access selects board k (k = 0..3) when the address lies in BASE + 64·2^k .. BASE + 64·2^k + 63, with BASE = 0x0300_0000. Board k's active-low strobe brd_strb_n[k] is low from the cycle after the access is captured until the cycle after the processor strobe is seen high.
- R2: An access to BASE .. BASE+0x3F, or to any address outside the four board windows, drives no board strobe. It still raises dsp_rdy, and a read returns zero.
- R3: A write outside the four board windows changes no board register.
- R4: At most one board strobe is low at a time. brd_rdy is high only for the selected board, and only while dsp_rdy is high. brd_rd (1 = read) shows the access direction for the selected board and stays 1 for every other board.
- R5: dsp_rdy rises at the WAIT_CYC-th rising clock edge after the edge at which dsp_strb_n is first sampled low (default 2). It is low before that edge.
- R6: Once dsp_rdy is high, it and dsp_rdata hold while dsp_strb_n stays low. They drop, with dsp_rdata going to zero, at the first edge that samples dsp_strb_n high.
- R7: Each board has 16 word slots selected by address bits [5:2]. Slots 1..15 are read/write storage, independent per board.
- R8: Slot 0 is the read-only status word. Bit 0 is the board's data-valid flag, bits 31:1 read zero, and writes to it have no effect.
- R9: A pulse on brd_evt[k] sets board k's flag, and brd_irq[k] is high from the next edge. A read of board k's slot 0 clears the flag at the edge that raises dsp_rdy. An event in that same cycle wins, and the flag stays set.
- R10: After reset, dsp_rdy is low, all board strobes are high, all interrupts are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_strb_n | input | 1 | Processor access strobe, active low |
| dsp_rd | input | 1 | Access direction, 1 = read |
| dsp_addr | input | 32 | Byte address |
| dsp_wdata | input | 32 | Write data |
| dsp_rdata | output | 32 | Read data, valid while dsp_rdy is high |
| dsp_rdy | output | 1 | Access complete |
| brd_strb_n | output | NUM_BRD | Per-board strobe, active low |
| brd_rd | output | NUM_BRD | Per-board direction, 1 = read |
| brd_rdy | output | NUM_BRD | Per-board ready |
| brd_evt | input | NUM_BRD | Per-board data-waiting event pulse |
| brd_irq | output | NUM_BRD | Per-board interrupt toward the processor |

## Verification
A stuck or miscounted wait counter shows at once as dsp_rdy rising on the wrong edge of the first access. A wrong latched board select shows in that same access as the wrong brd_strb_n or brd_rdy bit. A mis-decoded window only shows as corrupted storage on a later read-back, so every write is followed by reads of neighbouring boards and slots. A faulty flag shows on brd_irq one cycle after an event, or on the edge a status read completes.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
    localparam int DW = 32;
    localparam int AW = 32;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACK  = 2'd2
    } phase_e;
endpackage

// File: rtl/dbb_decode.sv
module dbb_decode #(
    parameter int                    NB   = 4,
    parameter int                    WB   = 6,
    parameter logic [dbb_pkg::AW-1:0] BASE = 32'h0300_0000
) (
    input  logic [dbb_pkg::AW-1:0] addr,
    output logic [NB-1:0]          sel
);
    // Window k starts at BASE plus one window size shifted left by k.
    for (genvar k = 0; k < NB; k++) begin : g_win
        localparam logic [dbb_pkg::AW-1:0] WSTART = BASE + (32'd1 << (WB + k));
        assign sel[k] = (addr[dbb_pkg::AW-1:WB] == WSTART[dbb_pkg::AW-1:WB]);
    end
endmodule

// File: rtl/dbb_regfile.sv
module dbb_regfile #(
    parameter int REGS = 16,
    parameter int IW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   clr,
    input  logic                   evt,
    input  logic [IW-1:0]          idx,
    input  logic [dbb_pkg::DW-1:0] wdata,
    output logic [dbb_pkg::DW-1:0] rdata,
    output logic                   flag
);
    typedef struct packed {
        logic [REGS-1:0][dbb_pkg::DW-1:0] mem;
        logic                             flag;
    } rf_s;

    rf_s rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we && (idx != '0)) begin
            rf_d.mem[idx] = wdata;
        end
        if (evt) begin
            rf_d.flag = 1'b1;
        end else if (clr) begin
            rf_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata = (idx == '0) ? {{(dbb_pkg::DW-1){1'b0}}, rf_q.flag} : rf_q.mem[idx];
    assign flag  = rf_q.flag;
endmodule

// File: rtl/dbb_fsm.sv
module dbb_fsm #(
    parameter int NB       = 4,
    parameter int IW       = 4,
    parameter int WAIT_CYC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strb_n,
    input  logic                   rd,
    input  logic [NB-1:0]          dec_sel,
    input  logic [IW-1:0]          dec_idx,
    input  logic [dbb_pkg::DW-1:0] wdata,
    input  logic [dbb_pkg::DW-1:0] rd_word,
    output logic                   active,
    output logic [NB-1:0]          sel,
    output logic                   acc_rd,
    output logic [IW-1:0]          idx,
    output logic [dbb_pkg::DW-1:0] acc_wdata,
    output logic                   fire,
    output logic                   rdy,
    output logic [dbb_pkg::DW-1:0] rdata
);
    import dbb_pkg::*;

    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] CNT_END = CW'(WAIT_CYC);

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
        logic [NB-1:0]   sel;
        logic            rd;
        logic [IW-1:0]   idx;
        logic [DW-1:0]   wdata;
        logic            rdy;
        logic [DW-1:0]   rdata;
    } fsm_s;

    fsm_s st_d, st_q;
    logic fire_c;

    assign fire_c = (st_q.phase == PH_WAIT) && (st_q.cnt == CNT_END);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (!strb_n) begin
                    st_d.phase = PH_WAIT;
                    st_d.cnt   = CW'(1);
                    st_d.sel   = dec_sel;
                    st_d.rd    = rd;
                    st_d.idx   = dec_idx;
                    st_d.wdata = wdata;
                end
            end
            PH_WAIT: begin
                if (fire_c) begin
                    st_d.phase = PH_ACK;
                    st_d.rdy   = 1'b1;
                    st_d.rdata = st_q.rd ? rd_word : '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_ACK: begin
                if (strb_n) begin
                    st_d.phase = PH_IDLE;
                    st_d.rdy   = 1'b0;
                    st_d.rdata = '0;
                    st_d.sel   = '0;
                    st_d.cnt   = '0;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = (st_q.phase != PH_IDLE);
    assign sel       = st_q.sel;
    assign acc_rd    = st_q.rd;
    assign idx       = st_q.idx;
    assign acc_wdata = st_q.wdata;
    assign fire      = fire_c;
    assign rdy       = st_q.rdy;
    assign rdata     = st_q.rdata;
endmodule

// File: rtl/dsp_board_bus.sv
module dsp_board_bus #(
    parameter int          NUM_BRD   = 4,
    parameter int          REGS      = 16,
    parameter int          WAIT_CYC  = 2,
    parameter logic [31:0] BASE_ADDR = 32'h0300_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dsp_strb_n,
    input  logic               dsp_rd,
    input  logic [31:0]        dsp_addr,
    input  logic [31:0]        dsp_wdata,
    output logic [31:0]        dsp_rdata,
    output logic               dsp_rdy,
    output logic [NUM_BRD-1:0] brd_strb_n,
    output logic [NUM_BRD-1:0] brd_rd,
    output logic [NUM_BRD-1:0] brd_rdy,
    input  logic [NUM_BRD-1:0] brd_evt,
    output logic [NUM_BRD-1:0] brd_irq
);
    localparam int WIN_BYTES = REGS * 4;
    localparam int WB        = $clog2(WIN_BYTES);
    localparam int IW        = $clog2(REGS);

    logic [NUM_BRD-1:0] dec_sel;
    logic [NUM_BRD-1:0] sel;
    logic               active;
    logic               acc_rd;
    logic [IW-1:0]      idx;
    logic [31:0]        acc_wdata;
    logic               fire;
    logic [31:0]        rd_word;
    logic [31:0]        rf_rdata [NUM_BRD];

    dbb_decode #(
        .NB   (NUM_BRD),
        .WB   (WB),
        .BASE (BASE_ADDR)
    ) u_decode (
        .addr (dsp_addr),
        .sel  (dec_sel)
    );

    dbb_fsm #(
        .NB       (NUM_BRD),
        .IW       (IW),
        .WAIT_CYC (WAIT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_n    (dsp_strb_n),
        .rd        (dsp_rd),
        .dec_sel   (dec_sel),
        .dec_idx   (dsp_addr[WB-1:2]),
        .wdata     (dsp_wdata),
        .rd_word   (rd_word),
        .active    (active),
        .sel       (sel),
        .acc_rd    (acc_rd),
        .idx       (idx),
        .acc_wdata (acc_wdata),
        .fire      (fire),
        .rdy       (dsp_rdy),
        .rdata     (dsp_rdata)
    );

    for (genvar b = 0; b < NUM_BRD; b++) begin : g_brd
        dbb_regfile #(
            .REGS (REGS),
            .IW   (IW)
        ) u_rf (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (fire && !acc_rd && sel[b]),
            .clr   (fire && acc_rd && sel[b] && (idx == '0)),
            .evt   (brd_evt[b]),
            .idx   (idx),
            .wdata (acc_wdata),
            .rdata (rf_rdata[b]),
            .flag  (brd_irq[b])
        );

        assign brd_strb_n[b] = !(active && sel[b]);
        assign brd_rd[b]     = sel[b] ? acc_rd : 1'b1;
        assign brd_rdy[b]    = dsp_rdy && sel[b];
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BRD; b++) begin
            if (sel[b]) begin
                rd_word = rd_word | rf_rdata[b];
            end
        end
    end
endmodule

// File: rtl/dsp_board_bus_chk.sv
module dsp_board_bus_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strb_n,
    input logic          rdy,
    input logic [31:0]   rdata,
    input logic [NB-1:0] brd_strb_n,
    input logic [NB-1:0] brd_rd,
    input logic [NB-1:0] brd_rdy,
    input logic [NB-1:0] irq
);
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~brd_strb_n));

    a_r4_rdy_fanout: assert property (@(posedge clk) disable iff (!rst_n)
        (brd_rdy != '0) |-> (rdy && ((brd_rdy & brd_strb_n) == '0)));

    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $past(rdy)) |-> $stable(rdata));

    a_r6_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !strb_n) |=> rdy);

    a_r2_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && (&brd_strb_n)) |-> (rdata == '0));

    for (genvar b = 0; b < NB; b++) begin : g_irq
        a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[b]) |-> (rdy && !brd_strb_n[b] && brd_rd[b]));
    end
endmodule

bind dsp_board_bus dsp_board_bus_chk #(.NB(NUM_BRD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_n     (dsp_strb_n),
    .rdy        (dsp_rdy),
    .rdata      (dsp_rdata),
    .brd_strb_n (brd_strb_n),
    .brd_rd     (brd_rd),
    .brd_rdy    (brd_rdy),
    .irq        (brd_irq)
);

// File: tb/tb_dsp_board_bus.sv
`timescale 1ns/1ps
module tb_dsp_board_bus;
    localparam int WAIT_CYC = 2;
    localparam logic [31:0] BASE = 32'h0300_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dsp_strb_n = 1'b1;
    logic        dsp_rd = 1'b1;
    logic [31:0] dsp_addr = '0;
    logic [31:0] dsp_wdata = '0;
    logic [31:0] dsp_rdata;
    logic        dsp_rdy;
    logic [3:0]  brd_strb_n, brd_rd, brd_rdy, brd_irq;
    logic [3:0]  brd_evt = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dsp_board_bus #(.WAIT_CYC(WAIT_CYC), .BASE_ADDR(BASE)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dsp_strb_n (dsp_strb_n),
        .dsp_rd     (dsp_rd),
        .dsp_addr   (dsp_addr),
        .dsp_wdata  (dsp_wdata),
        .dsp_rdata  (dsp_rdata),
        .dsp_rdy    (dsp_rdy),
        .brd_strb_n (brd_strb_n),
        .brd_rd     (brd_rd),
        .brd_rdy    (brd_rdy),
        .brd_evt    (brd_evt),
        .brd_irq    (brd_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] win(input int b, input int slot);
        return BASE + (32'd64 << b) + 32'(slot * 4);
    endfunction

    // One bus access; checks handshake timing, strobes and hold (R1 R4 R5 R6).
    task automatic bus_acc(input logic rd, input logic [31:0] a, input logic [31:0] wd,
                           input logic [3:0] exp_sel, input logic [3:0] evt_ack,
                           output logic [31:0] rd_out);
        int n = 0;
        logic [31:0] d0;
        dsp_addr = a; dsp_rd = rd; dsp_wdata = wd; dsp_strb_n = 1'b0;
        do begin
            @(negedge clk);
            n++;
            brd_evt = (n == WAIT_CYC) ? evt_ack : 4'h0;
        end while (!dsp_rdy && n < 20);
        brd_evt = 4'h0;
        chk("R5 ready edge count", 32'(n), 32'(WAIT_CYC + 1));
        chk("R1 board strobe", {28'h0, brd_strb_n}, {28'h0, ~exp_sel});
        chk("R4 board ready", {28'h0, brd_rdy}, {28'h0, exp_sel});
        chk("R4 board direction", {28'h0, brd_rd}, {28'h0, rd ? 4'hF : ~exp_sel});
        d0 = dsp_rdata;
        @(negedge clk);
        chk("R6 ready held", {31'h0, dsp_rdy}, 32'h1);
        chk("R6 data held", dsp_rdata, d0);
        dsp_strb_n = 1'b1;
        @(negedge clk);
        chk("R6 ready dropped", {31'h0, dsp_rdy}, 32'h0);
        chk("R6 data cleared", dsp_rdata, 32'h0);
        chk("R4 strobes released", {28'h0, brd_strb_n}, 32'hF);
        rd_out = d0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R10 rdy after reset", {31'h0, dsp_rdy}, 32'h0);
        chk("R10 strobes after reset", {28'h0, brd_strb_n}, 32'hF);
        chk("R10 irq after reset", {28'h0, brd_irq}, 32'h0);
        bus_acc(1'b1, win(3, 9), 32'h0, 4'b1000, 4'h0, r);
        chk("R10 register zero", r, 32'h0);
    endtask

    task automatic t_boards();
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            bus_acc(1'b0, win(b, 3), 32'hA5A0_0000 + 32'(b), 4'(1 << b), 4'h0, r);
        end
        for (int b = 0; b < 4; b++) begin
            bus_acc(1'b1, win(b, 3), 32'h0, 4'(1 << b), 4'h0, r);
            chk("R1 R7 per-board readback", r, 32'hA5A0_0000 + 32'(b));
        end
    endtask

    task automatic t_slots();
        logic [31:0] r;
        bus_acc(1'b0, win(2, 15), 32'hDEAD_BEEF, 4'b0100, 4'h0, r);
        bus_acc(1'b0, win(2, 1), 32'h1234_5678, 4'b0100, 4'h0, r);
        bus_acc(1'b1, win(2, 15), 32'h0, 4'b0100, 4'h0, r);
        chk("R7 slot 15", r, 32'hDEAD_BEEF);
        bus_acc(1'b1, win(2, 1), 32'h0, 4'b0100, 4'h0, r);
        chk("R7 slot 1", r, 32'h1234_5678);
        bus_acc(1'b1, win(1, 15), 32'h0, 4'b0010, 4'h0, r);
        chk("R7 other board untouched", r, 32'h0);
    endtask

    task automatic t_unused();
        logic [31:0] r;
        logic [31:0] holes [5] = '{BASE + 32'h0C, BASE + 32'hCC, BASE + 32'h14C,
                                   BASE + 32'h24C, 32'h0200_004C};
        foreach (holes[i]) begin
            bus_acc(1'b0, holes[i], 32'hFFFF_FFFF, 4'h0, 4'h0, r);
            bus_acc(1'b1, holes[i], 32'h0, 4'h0, 4'h0, r);
            chk("R2 unused read zero", r, 32'h0);
        end
        for (int b = 0; b < 4; b++) begin
            bus_acc(1'b1, win(b, 3), 32'h0, 4'(1 << b), 4'h0, r);
            chk("R3 registers unchanged", r, 32'hA5A0_0000 + 32'(b));
        end
    endtask

    task automatic t_status();
        logic [31:0] r;
        bus_acc(1'b0, win(0, 0), 32'hFFFF_FFFF, 4'b0001, 4'h0, r);
        bus_acc(1'b1, win(0, 0), 32'h0, 4'b0001, 4'h0, r);
        chk("R8 status write ignored", r, 32'h0);
        @(negedge clk); brd_evt = 4'b0100;
        @(negedge clk); brd_evt = 4'h0;
        chk("R9 irq set", {28'h0, brd_irq}, 32'h4);
        bus_acc(1'b1, win(2, 0), 32'h0, 4'b0100, 4'h0, r);
        chk("R8 status flag bit", r, 32'h1);
        chk("R9 irq cleared by read", {28'h0, brd_irq}, 32'h0);
        bus_acc(1'b1, win(2, 0), 32'h0, 4'b0100, 4'h0, r);
        chk("R8 status after clear", r, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] r;
        @(negedge clk); brd_evt = 4'b0010;
        @(negedge clk); brd_evt = 4'h0;
        bus_acc(1'b1, win(1, 2), 32'h0, 4'b0010, 4'h0, r);
        chk("R9 non-status read keeps irq", {28'h0, brd_irq}, 32'h2);
        bus_acc(1'b1, win(1, 0), 32'h0, 4'b0010, 4'b0010, r);
        chk("R9 collide read value", r, 32'h1);
        chk("R9 event beats clear", {28'h0, brd_irq}, 32'h2);
        bus_acc(1'b1, win(1, 0), 32'h0, 4'b0010, 4'h0, r);
        chk("R9 final clear", {28'h0, brd_irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boards();
        t_slots();
        t_unused();
        t_status();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule